// File: doc/BRIEF.md
# Auto-Reload Baud Rate Timer

This block turns a fast oscillator clock into the bit-rate strobe of an asynchronous serial port. A prescaler marks one machine cycle every twelve oscillator clocks. An 8-bit counter advances once per machine cycle. When the counter wraps past its top value it loads a programmable start value and gives a one-clock overflow pulse. A second divider counts these overflows. It gives one baud strobe per 32 overflows, or per 16 when the rate-doubling input is set.

The resulting bit rate is `2^dbl * f_clk / (32 * 12 * (256 - reload))`. With an 11.059 MHz oscillator, a start value of 0xFD gives 9600 bit/s normally and 19200 bit/s doubled. The values 0xFA, 0xF4, 0xE8 and 0xA0 give 4800, 2400, 1200 and 300 bit/s. The overflow pulse is intended as a strobe only. It comes far too often to be serviced as a software interrupt.

Top module: `reload_baud_gen`

## Requirements
- R1: The prescaler divides the clock by PRESCALE (12), and the counter advances by exactly one per machine cycle while `run_en` is high.
- R2: When the counter advances from 0xFF, `ovf_pulse` is high for exactly one clock. In steady state the overflow period is 12 × (256 − `reload_val`) clocks.
- R3: On overflow the counter loads `reload_val`. A change of `reload_val` during a period leaves that period's length unchanged and takes effect from the following period.
- R4: With `dbl_sel` = 0, `baud_tick` fires once every 32 overflows.
- R5: With `dbl_sel` = 1, `baud_tick` fires once every 16 overflows.
- R6: `baud_tick` is one clock wide and is high in the clock directly after the `ovf_pulse` that completes its group.
- R7: While `run_en` is low, both the prescaler phase and the count hold. A pause of N clocks lengthens the current overflow period by exactly N clocks and produces no pulse.
- R8: A change of `dbl_sel` restarts the overflow divider. The first tick after the change follows a full group of 16 or 32 overflows.
- R9: During reset both outputs are low, and the count, the prescaler phase and the divider are zero. The first overflow therefore comes 3072 clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Counting enable; low freezes the timer |
| reload_val | input | 8 | Start value loaded on each overflow |
| dbl_sel | input | 1 | 1 = divide overflows by 16, 0 = divide by 32 |
| ovf_pulse | output | 1 | One-clock pulse on each counter overflow |
| baud_tick | output | 1 | One-clock bit-rate strobe |

## Verification
The overflow spacing is measured in four cases:
- The first period after reset, which separates a counter that starts at zero from one that starts at the start value.
- Short steady periods at 0xFD, and later periods at 0xF4 and 0xA0, which show whether the divide-by-12 prescaler and the reload value combine into the correct length.
- A start-value change in the middle of a period, which shows whether the new value is taken at the next overflow or too early.
- A 50-clock pause of `run_en`, which shows whether the pause only delays counting or also loses prescaler phase.

Baud strobes are counted in overflows under both divide settings, and across each change of `dbl_sel`, which separates divide-by-16 from divide-by-32 and shows whether the divider restarts. Each strobe must also follow its overflow by exactly one clock.

// File: rtl/bgen_pkg.sv
package bgen_pkg;
  // Rate selection of the overflow divider
  typedef enum logic {
    RATE_NORMAL = 1'b0,   // one tick per full group of overflows
    RATE_DOUBLE = 1'b1    // one tick per half group
  } rate_mode_e;
endpackage

// File: rtl/mc_prescaler.sv
module mc_prescaler #(
  parameter int PRESCALE = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  output logic mc_tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= '0;
    end else if (run_en) begin
      ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
    end
  end

  assign mc_tick = run_en && (ph_q == LAST);

  // R1
  mc_gap_chk: assert property (@(posedge clk) disable iff (rst)
    mc_tick |=> !mc_tick);
endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mc_tick,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (mc_tick) begin
        if (cnt_q == TOP) begin
          cnt_q <= reload_val;
          ovf_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R3
  reload_load_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> (cnt_q == $past(reload_val)));

  // R2
  ovf_width_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> !ovf_q);
endmodule

// File: rtl/ovf_divider.sv
module ovf_divider
  import bgen_pkg::*;
#(
  parameter int DIV_LOG2 = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic ovf,
  input  logic dbl_sel,
  output logic tick_q
);
  localparam int FAST_W = DIV_LOG2 - 1;

  logic [DIV_LOG2-1:0] dc_q;
  rate_mode_e          mode_q;
  rate_mode_e          mode_now;
  logic                restart;
  logic                group_end;

  assign mode_now = rate_mode_e'(dbl_sel);
  assign restart  = (mode_now != mode_q);

  generate
    if (FAST_W > 0) begin : g_split
      assign group_end = (mode_now == RATE_DOUBLE) ? (&dc_q[FAST_W-1:0]) : (&dc_q);
    end else begin : g_flat
      assign group_end = (mode_now == RATE_DOUBLE) ? 1'b1 : (&dc_q);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      dc_q   <= '0;
      mode_q <= RATE_NORMAL;
      tick_q <= 1'b0;
    end else begin
      mode_q <= mode_now;
      tick_q <= 1'b0;
      if (restart) begin
        dc_q <= '0;
      end else if (ovf) begin
        dc_q   <= dc_q + 1'b1;
        tick_q <= group_end;
      end
    end
  end

  // R6
  tick_after_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    tick_q |-> $past(ovf));

  // R6
  tick_width_chk: assert property (@(posedge clk) disable iff (rst)
    tick_q |=> !tick_q);
endmodule

// File: rtl/reload_baud_gen.sv
module reload_baud_gen #(
  parameter int CNT_W    = 8,
  parameter int PRESCALE = 12,
  parameter int DIV_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             dbl_sel,
  output logic             ovf_pulse,
  output logic             baud_tick
);
  logic             mc_tick;
  logic [CNT_W-1:0] tmr_cnt;

  mc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run_en  (run_en),
    .mc_tick (mc_tick)
  );

  reload_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk        (clk),
    .rst        (rst),
    .mc_tick    (mc_tick),
    .reload_val (reload_val),
    .cnt_q      (tmr_cnt),
    .ovf_q      (ovf_pulse)
  );

  ovf_divider #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk     (clk),
    .rst     (rst),
    .ovf     (ovf_pulse),
    .dbl_sel (dbl_sel),
    .tick_q  (baud_tick)
  );

  // R7
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> $stable(tmr_cnt));

  // R7
  no_ovf_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !ovf_pulse) |=> !ovf_pulse);
endmodule

// File: tb/tb_reload_baud_gen.sv
module tb_reload_baud_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run_en = 1'b0;
  logic [7:0] reload_val = 8'hFD;
  logic       dbl_sel = 1'b0;
  logic       ovf_pulse;
  logic       baud_tick;

  always #2 clk = ~clk;   // 250 MHz

  reload_baud_gen dut (
    .clk        (clk),
    .rst        (rst),
    .run_en     (run_en),
    .reload_val (reload_val),
    .dbl_sel    (dbl_sel),
    .ovf_pulse  (ovf_pulse),
    .baud_tick  (baud_tick)
  );

  typedef struct {
    int    gap;
    string tag;
  } exp_item_t;

  exp_item_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int last_ovf_cyc = 0;
  int ovf_seen = 0;
  int ovf_since = 0;
  int exp_div = 32;
  int n_ticks = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Driver: queue expected overflow spacings
  task automatic push_gap(input int gap, input int count, input string tag);
    for (int i = 0; i < count; i++) begin
      exp_item_t it;
      it.gap = gap;
      it.tag = tag;
      exp_q.push_back(it);
    end
  endtask

  task automatic wait_ovf(input int n);
    int target;
    target = ovf_seen + n;
    while (ovf_seen < target) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (baud_tick) begin
        n_ticks++;
        check(last_ovf_cyc == cyc - 1, "R6 tick follows overflow", cyc - last_ovf_cyc, 1);
        check(ovf_since == exp_div, (exp_div == 16) ? "R5 overflows per tick" : "R4 overflows per tick",
              ovf_since, exp_div);
        ovf_since = 0;
      end
      if (ovf_pulse) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected overflow", cyc - last_ovf_cyc, 0);
        end else begin
          exp_item_t it;
          it = exp_q.pop_front();
          check(cyc - last_ovf_cyc == it.gap, it.tag, cyc - last_ovf_cyc, it.gap);
        end
        last_ovf_cyc = cyc;
        ovf_since++;
        ovf_seen++;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9 reset state
    check(ovf_pulse == 1'b0, "R9 ovf_pulse in reset", ovf_pulse, 0);
    check(baud_tick == 1'b0, "R9 baud_tick in reset", baud_tick, 0);

    // R9 first period from zero, then R1/R2 steady periods at 0xFD
    push_gap(3072, 1, "R9 first overflow after reset");
    push_gap(12 * (256 - 8'hFD), 40, "R1 R2 period at 0xFD");
    rst = 1'b0;
    run_en = 1'b1;
    wait_ovf(41);

    // R8/R5: switch to doubled rate between overflows
    repeat (3) @(negedge clk);
    dbl_sel = 1'b1;
    ovf_since = 0;
    exp_div = 16;
    push_gap(36, 20, "R5 R8 period at 0xFD doubled");
    wait_ovf(20);

    // R3: change reload in the middle of a period
    repeat (10) @(negedge clk);
    reload_val = 8'hF4;
    push_gap(36, 1, "R3 period in progress unaffected");
    push_gap(144, 33, "R3 new reload from next period");
    wait_ovf(34);

    // R7: pause for 50 clocks
    repeat (5) @(negedge clk);
    run_en = 1'b0;
    repeat (50) @(negedge clk);
    run_en = 1'b1;
    push_gap(144 + 50, 1, "R7 pause lengthens period");
    push_gap(144, 2, "R7 period after pause");
    wait_ovf(3);

    // R4/R8: back to normal rate, slow reload
    repeat (3) @(negedge clk);
    dbl_sel = 1'b0;
    reload_val = 8'hA0;
    ovf_since = 0;
    exp_div = 32;
    push_gap(144, 1, "R3 period in progress at 0xF4");
    push_gap(12 * (256 - 8'hA0), 33, "R4 period at 0xA0");
    wait_ovf(34);
    repeat (5) @(negedge clk);

    check(n_ticks == 5, "R4 R5 total baud ticks", n_ticks, 5);
    check(exp_q.size() == 0, "R2 pending overflows", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule